// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

The block moves data between a narrow A port and a wide B port made of two equal halves, a low half and a high half. Toward B, two narrow words presented on A in consecutive cycles are captured into two half registers, each under its own active-low capture enable. Once both are loaded, they are driven together as one wide word. Toward A, a select input picks one half of the wide input. That half is loaded into a storage register, and from there into an output register that drives A, so A changes only on a clock edge.

Every control input (the two capture enables, the select and the three active-low output enables) is first captured into a control register. Each control therefore acts one clock after it is sampled. Output enables are modelled as valid flags beside the data. A port that is not enabled reports its flag low and shows zero. Reset is asynchronous and active-low, and its release must be synchronous to the clock. Reset clears all data and control registers and leaves every port disabled.

Top module: `bus_pair_exchanger`

## Requirements
- R1: When cke1_n (or cke2_n) was low at the previous edge, the low half (or high half) register loads a_in at the current edge.
- R2: When the registered capture enable of a half is high, that half register keeps its value through any a_in activity.
- R3: Two words written in sequence, first under cke1_n and then under cke2_n, appear together as b_out = {second word, first word}, with b_out[11:0] the low half.
- R4: A control input changed before an edge has no effect on data or flags until that edge has registered it.
- R5: With registered sel = 0 the storage register loads b_in[11:0]; with registered sel = 1 it loads b_in[23:12].
- R6: The A output register loads the storage register one edge after the storage register loads, so a selected half reaches a_out two edges after it is sampled.
- R7: With a registered output enable low, the port's valid flag is 1 and its register contents are shown.
- R8: With a registered output enable high, the port's valid flag is 0 and its data bits read zero, independently for a_out, b_out[11:0] and b_out[23:12].
- R9: While rst_n is low, every output reads zero and every valid flag is 0. Immediately after release the data reads zero and the flags stay 0 until the output enables are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | 12 | Narrow word toward B |
| b_in | input | 24 | Wide word toward A; [11:0] low half, [23:12] high half |
| cke1_n | input | 1 | Active-low capture enable of the low B half |
| cke2_n | input | 1 | Active-low capture enable of the high B half |
| sel | input | 1 | Half select toward A: 0 low, 1 high |
| oea_n | input | 1 | Active-low output enable of A |
| oeb1_n | input | 1 | Active-low output enable of the low B half |
| oeb2_n | input | 1 | Active-low output enable of the high B half |
| a_out | output | 12 | Registered narrow word, zero when disabled |
| a_valid | output | 1 | A is driven |
| b_out | output | 24 | Paired wide word, each half zero when disabled |
| b1_valid | output | 1 | Low B half is driven |
| b2_valid | output | 1 | High B half is driven |

## Verification
The checker assumes that reset is released away from a rising edge. It also assumes that data inputs have a known value at every edge, because its data properties compare register contents with the sampled a_in and b_in. The bench drives every input just after a falling edge. It holds a_in and b_in at defined values throughout, including parking b_in at zero between select vectors. It releases reset on a falling edge, so each property sees clean, settled inputs.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef struct packed {
    logic cke1_n;
    logic cke2_n;
    logic sel;
    logic oea_n;
    logic oeb1_n;
    logic oeb2_n;
  } bx_ctl_t;

  localparam bx_ctl_t CTL_RESET = '{cke1_n: 1'b1, cke2_n: 1'b1, sel: 1'b0,
                                    oea_n: 1'b1, oeb1_n: 1'b1, oeb2_n: 1'b1};
endpackage

// File: rtl/bx_ctl_regs.sv
module bx_ctl_regs
  import bx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bx_ctl_t ctl_d,
  output bx_ctl_t ctl_q
);
  bx_ctl_t ctl_nxt;

  always_comb begin
    ctl_nxt = ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
  parameter int HALF_W = 12,
  parameter int HALVES = 2,
  localparam int WIDE_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] a_in,
  input  logic [HALVES-1:0] cke_n,
  output logic [WIDE_W-1:0] b_hold
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] half_nxt;

    always_comb begin
      if (!cke_n[h]) half_nxt = a_in;
      else           half_nxt = half_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= half_nxt;
    end

    assign b_hold[h*HALF_W +: HALF_W] = half_q;
  end
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path #(
  parameter int HALF_W = 12,
  localparam int WIDE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE_W-1:0] b_in,
  input  logic              sel_q,
  output logic [HALF_W-1:0] store_q,
  output logic [HALF_W-1:0] a_q
);
  logic [HALF_W-1:0] store_nxt;
  logic [HALF_W-1:0] a_nxt;

  always_comb begin
    store_nxt = sel_q ? b_in[WIDE_W-1:HALF_W] : b_in[HALF_W-1:0];
    a_nxt     = store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      a_q     <= '0;
    end else begin
      store_q <= store_nxt;
      a_q     <= a_nxt;
    end
  end
endmodule

// File: rtl/bus_pair_exchanger.sv
module bus_pair_exchanger
  import bx_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int WIDE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] a_in,
  input  logic [WIDE_W-1:0] b_in,
  input  logic              cke1_n,
  input  logic              cke2_n,
  input  logic              sel,
  input  logic              oea_n,
  input  logic              oeb1_n,
  input  logic              oeb2_n,
  output logic [HALF_W-1:0] a_out,
  output logic              a_valid,
  output logic [WIDE_W-1:0] b_out,
  output logic              b1_valid,
  output logic              b2_valid
);
  bx_ctl_t           ctl_d;
  bx_ctl_t           ctl_q;
  logic [WIDE_W-1:0] b_hold;
  logic [HALF_W-1:0] store_q;
  logic [HALF_W-1:0] a_q;

  always_comb begin
    ctl_d.cke1_n = cke1_n;
    ctl_d.cke2_n = cke2_n;
    ctl_d.sel    = sel;
    ctl_d.oea_n  = oea_n;
    ctl_d.oeb1_n = oeb1_n;
    ctl_d.oeb2_n = oeb2_n;
  end

  bx_ctl_regs u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_d (ctl_d),
    .ctl_q (ctl_q)
  );

  bx_a2b_path #(.HALF_W(HALF_W), .HALVES(2)) u_a2b (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (a_in),
    .cke_n  ({ctl_q.cke2_n, ctl_q.cke1_n}),
    .b_hold (b_hold)
  );

  bx_b2a_path #(.HALF_W(HALF_W)) u_b2a (
    .clk     (clk),
    .rst_n   (rst_n),
    .b_in    (b_in),
    .sel_q   (ctl_q.sel),
    .store_q (store_q),
    .a_q     (a_q)
  );

  always_comb begin
    a_valid  = !ctl_q.oea_n;
    b1_valid = !ctl_q.oeb1_n;
    b2_valid = !ctl_q.oeb2_n;
    a_out                    = a_valid  ? a_q                       : '0;
    b_out[HALF_W-1:0]        = b1_valid ? b_hold[HALF_W-1:0]        : '0;
    b_out[WIDE_W-1:HALF_W]   = b2_valid ? b_hold[WIDE_W-1:HALF_W]   : '0;
  end
endmodule

// File: rtl/bx_chk.sv
module bx_chk
  import bx_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int WIDE_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] a_in,
  input logic [WIDE_W-1:0] b_in,
  input bx_ctl_t           ctl_d,
  input bx_ctl_t           ctl_q,
  input logic [WIDE_W-1:0] b_hold,
  input logic [HALF_W-1:0] store_q,
  input logic [HALF_W-1:0] a_q,
  input logic [HALF_W-1:0] a_out,
  input logic              a_valid,
  input logic [WIDE_W-1:0] b_out,
  input logic              b1_valid
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !ctl_q.cke1_n |=> b_hold[HALF_W-1:0] == $past(a_in));

  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && ctl_q.cke2_n |=> $stable(b_hold[WIDE_W-1:HALF_W]));

  // R4
  ctl_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> ctl_q == $past(ctl_d));

  // R5
  store_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> store_q == ($past(ctl_q.sel) ? $past(b_in[WIDE_W-1:HALF_W])
                                            : $past(b_in[HALF_W-1:0])));

  // R6
  a_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> a_q == $past(store_q));

  // R8
  a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.oea_n |-> (a_out == '0) && !a_valid);

  // R8
  b1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.oeb1_n |-> (b_out[HALF_W-1:0] == '0) && !b1_valid);
endmodule

bind bus_pair_exchanger bx_chk #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_in     (a_in),
  .b_in     (b_in),
  .ctl_d    (ctl_d),
  .ctl_q    (ctl_q),
  .b_hold   (b_hold),
  .store_q  (store_q),
  .a_q      (a_q),
  .a_out    (a_out),
  .a_valid  (a_valid),
  .b_out    (b_out),
  .b1_valid (b1_valid)
);

// File: tb/bus_pair_exchanger_test.sv
module bus_pair_exchanger_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int NV = 8;
  // {sel, b_in, expected a_out}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 24'hABC123, 12'h123},
    {1'b1, 24'hABC123, 12'hABC},
    {1'b0, 24'hFFF000, 12'h000},
    {1'b1, 24'hFFF000, 12'hFFF},
    {1'b1, 24'h0005A5, 12'h000},
    {1'b0, 24'h0005A5, 12'h5A5},
    {1'b1, 24'h800001, 12'h800},
    {1'b0, 24'h800001, 12'h001}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  a_in;
  logic [2*W-1:0] b_in;
  logic cke1_n, cke2_n, sel, oea_n, oeb1_n, oeb2_n;
  logic [W-1:0]  a_out;
  logic          a_valid;
  logic [2*W-1:0] b_out;
  logic          b1_valid, b2_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_pair_exchanger #(.HALF_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .cke1_n(cke1_n), .cke2_n(cke2_n), .sel(sel),
    .oea_n(oea_n), .oeb1_n(oeb1_n), .oeb2_n(oeb2_n),
    .a_out(a_out), .a_valid(a_valid), .b_out(b_out),
    .b1_valid(b1_valid), .b2_valid(b2_valid)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0;
    cke1_n = 1'b1; cke2_n = 1'b1; sel = 1'b0;
    oea_n = 1'b0; oeb1_n = 1'b0; oeb2_n = 1'b0;
    repeat (3) tick();
    // R9: outputs cleared and disabled under reset even with enables low
    check("R9 reset a", {19'd0, a_valid, a_out}, 32'd0);
    check("R9 reset b", {6'd0, b2_valid, b1_valid, b_out}, 32'd0);
    rst_n = 1'b1;
    #1;
    check("R9 after release", {5'd0, a_valid, b2_valid, b1_valid, b_out}, 32'd0);
    tick();
    // R7: enables registered, zero contents shown as driven
    check("R7 valid flags", {29'd0, a_valid, b2_valid, b1_valid}, 32'd7);
    check("R9 data cleared", {8'd0, b_out} | {20'd0, a_out}, 32'd0);

    // R5 R6: select table
    for (int i = 0; i < NV; i++) begin
      sel = VEC[i][36]; b_in = '0;
      tick();
      b_in = VEC[i][35:12];
      tick();
      check("R6 one edge not yet", {20'd0, a_out}, 32'd0);
      b_in = '0;
      tick();
      check("R5 selected half", {20'd0, a_out}, {20'd0, VEC[i][11:0]});
    end

    // R1 R3: pairing two sequential words
    cke1_n = 1'b0; a_in = 12'h111;
    tick();
    a_in = 12'h3C5; cke1_n = 1'b1; cke2_n = 1'b0;
    tick();
    check("R1 low half captured", {20'd0, b_out[11:0]}, 32'h3C5);
    a_in = 12'hA96; cke2_n = 1'b1;
    tick();
    a_in = 12'h777;
    tick();
    check("R3 paired word", {8'd0, b_out}, 32'h00A963C5);
    // R2: hold through a_in activity
    a_in = 12'h0F0;
    repeat (3) tick();
    check("R2 halves held", {8'd0, b_out}, 32'h00A963C5);

    // R4: enable applied with data in same cycle does not capture yet
    cke2_n = 1'b0; a_in = 12'h5E5;
    tick();
    check("R4 capture delayed", {20'd0, b_out[23:12]}, 32'hA96);
    a_in = 12'h242; cke2_n = 1'b1;
    tick();
    check("R1 high half captured", {20'd0, b_out[23:12]}, 32'h242);

    // R8: disable low B half only
    oeb1_n = 1'b1;
    #1;
    check("R4 oe delayed", {31'd0, b1_valid}, 32'd1);
    tick();
    check("R8 low half off", {19'd0, b1_valid, b_out[11:0]}, 32'd0);
    check("R8 high half on", {19'd0, b2_valid, b_out[23:12]}, 32'h1242);
    oea_n = 1'b1;
    tick();
    check("R8 a off", {19'd0, a_valid, a_out}, 32'd0);
    oeb1_n = 1'b0;
    tick();
    check("R7 low half back", {19'd0, b1_valid, b_out[11:0]}, 32'h13C5);

    // R9: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check("R9 async clear", {6'd0, b2_valid, b1_valid, b_out}, 32'd0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R9 contents cleared", {6'd0, b2_valid, b1_valid, b_out}, 32'h3000000);

    done = 1'b1;
    finish_run();
  end
endmodule